// File: doc/BRIEF.md
# Descriptor vector element address unit

This unit turns a 64-bit vector descriptor and a 32-bit modifier into one checked, scaled element access. A request either supplies a new descriptor, which is latched into the unit's descriptor register, or reuses the descriptor already held there. The unit decodes the element size from the descriptor's type bits. In a modified access it checks the modifier against the descriptor's bound, and it scales the modifier so that it counts elements. It then forms a bit position from the origin and the displacement.

From that bit position the unit issues one or two 64-bit word reads over a valid/ready memory port. It takes two reads when the element crosses a word boundary. It returns the element right justified with the upper bits cleared. A failed bound check raises a bound interrupt instead of reading memory. A descriptor with an unimplemented size raises an illegal-descriptor flag instead. Only one access is in flight at a time.

Top module: `dva_unit`

## Requirements
- R1: After synchronous reset, req_ready is 1, and mem_req_valid, mem_rsp_ready, res_valid, bound_irq and illegal_flag are all 0.
- R2: The descriptor layout is: type in bits 63:56, bound (element count) in bits 55:32, byte origin in bits 31:0. In the type field, bits 2:0 hold log2 of the element size in bits (code 0 means 1 bit, up to code 6 meaning 64 bits). Type bit 3 set disables the bound check. Type bit 4 set disables scaling. Type bits 7:5 have no effect.
- R3: A request with req_load=1 uses req_desc and stores it in the descriptor register. This happens even when the request then faults. A request with req_load=0 uses the last stored descriptor.
- R4: In a modified access with the check enabled, the modifier is taken as signed. If it is negative, or if it is greater than or equal to the bound, the unit pulses bound_irq and makes no memory request.
- R5: When type bit 3 is set, any modifier value is accepted and the access proceeds.
- R6: The bit position is origin×8 + modifier×size, modulo 2^35. When type bit 4 is set it is origin×8 + modifier×8 instead. mem_addr is bit position >> 6. The low 6 bits give the offset, where offset 0 is the least significant bit of the word.
- R7: An unmodified access (req_modified=0) uses a modifier of zero and is never bound checked, even when the bound is 0.
- R8: Size codes 1 (2 bits) and 7 (128 bits) pulse illegal_flag and make no memory request. This flag takes priority over the bound check.
- R9: res_data holds the element right justified, with every bit above the element size cleared to 0.
- R10: When offset + size > 64, the unit reads word A and then word A+1 (modulo 2^29). The element's upper bits come from the low bits of word A+1.
- R11: mem_req_valid and mem_addr stay stable until mem_req_ready is seen. req_ready is 0 while an access is in progress.
- R12: Each accepted request yields exactly one single-cycle pulse of res_valid, bound_irq or illegal_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_load | input | 1 | Take req_desc as the new descriptor |
| req_desc | input | 64 | Descriptor supplied with the request |
| req_modified | input | 1 | Use req_modifier (1) or zero (0) |
| req_modifier | input | 32 | Signed element index |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 29 | 64-bit word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 64 | Returned store word |
| res_valid | output | 1 | Element result pulse |
| res_data | output | 64 | Right-justified element |
| bound_irq | output | 1 | Bound violation pulse |
| illegal_flag | output | 1 | Illegal descriptor pulse |

## Verification
A fault pulse (bound_irq or illegal_flag) is due in the cycle after the clock edge that accepts the request. The first mem_req_valid is also raised in that cycle. res_valid follows the edge that completes the last read response by one cycle. The bench samples every output at the falling edge. Its scoreboard pops an expected item only when a pulse appears, so a pulse that is missing, extra or of the wrong kind is caught against the item the driver pushed. The memory model checks every accepted read address against a second queue, in order, and that queue also covers the two-word case.

// File: rtl/dva_pkg.sv
package dva_pkg;
    localparam int DESC_W   = 64;
    localparam int WORD_W   = 64;
    localparam int TYPE_W   = 8;
    localparam int BOUND_W  = 24;
    localparam int ORIGIN_W = 32;
    localparam int MOD_W    = 32;
    localparam int BP_W     = ORIGIN_W + 3;
    localparam int OFF_W    = $clog2(WORD_W);
    localparam int WA_W     = BP_W - OFF_W;
    localparam int SZL_W    = 3;

    typedef struct packed {
        logic [TYPE_W-1:0]   kind;
        logic [BOUND_W-1:0]  bound;
        logic [ORIGIN_W-1:0] origin;
    } desc_t;

    typedef struct packed {
        logic             illegal;
        logic             bound_fail;
        logic [WA_W-1:0]  waddr;
        logic [OFF_W-1:0] boff;
        logic [SZL_W-1:0] szl;
        logic             span2;
    } plan_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FAULT, ST_REQ0, ST_RSP0, ST_REQ1, ST_RSP1, ST_DONE
    } state_t;

    function automatic logic [SZL_W-1:0] kind_szl(logic [TYPE_W-1:0] k);
        return k[2:0];
    endfunction

    function automatic logic kind_nocheck(logic [TYPE_W-1:0] k);
        return k[3];
    endfunction

    function automatic logic kind_noscale(logic [TYPE_W-1:0] k);
        return k[4];
    endfunction

    function automatic logic szl_unsupported(logic [SZL_W-1:0] s);
        return (s == 3'd1) || (s == 3'd7);
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(logic [SZL_W-1:0] s);
        logic [WORD_W-1:0] m;
        if (s >= 3'd6) m = '1;
        else           m = (64'd1 << (32'd1 << s)) - 64'd1;
        return m;
    endfunction
endpackage

// File: rtl/dva_desc_reg.sv
module dva_desc_reg
    import dva_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              use_new,
    input  logic [DESC_W-1:0] new_desc,
    output desc_t             eff_desc
);
    desc_t held_q;

    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (take) held_q <= desc_t'(new_desc);
    end

    assign eff_desc = use_new ? desc_t'(new_desc) : held_q;
endmodule

// File: rtl/dva_addr_gen.sv
module dva_addr_gen
    import dva_pkg::*;
(
    input  desc_t             desc,
    input  logic              modified,
    input  logic [MOD_W-1:0]  modifier,
    output plan_t             plan
);
    logic [SZL_W-1:0]  szl;
    logic [MOD_W-1:0]  m_eff;
    logic              out_of_range;
    logic [BP_W-1:0]   disp;
    logic [BP_W-1:0]   bitpos;
    logic [OFF_W:0]    span_end;

    always_comb begin
        szl   = kind_szl(desc.kind);
        m_eff = modified ? modifier : '0;
        out_of_range = m_eff[MOD_W-1] ||
                       (m_eff >= MOD_W'(desc.bound));
        if (kind_noscale(desc.kind)) disp = BP_W'(m_eff) << 3;
        else                         disp = BP_W'(m_eff) << szl;
        bitpos   = {desc.origin, 3'b000} + disp;
        span_end = {1'b0, bitpos[OFF_W-1:0]} + ((OFF_W+1)'(1) << szl);

        plan.illegal    = szl_unsupported(szl);
        plan.bound_fail = modified && !kind_nocheck(desc.kind) && out_of_range;
        plan.waddr      = bitpos[BP_W-1:OFF_W];
        plan.boff       = bitpos[OFF_W-1:0];
        plan.szl        = szl;
        plan.span2      = span_end > (OFF_W+1)'(WORD_W);
    end
endmodule

// File: rtl/dva_elem_align.sv
module dva_elem_align
    import dva_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  boff,
    input  logic [SZL_W-1:0]  szl,
    output logic [WORD_W-1:0] elem
);
    logic [2*WORD_W-1:0] joined;

    always_comb begin
        joined = {hi_word, lo_word} >> boff;
        elem   = joined[WORD_W-1:0] & size_mask(szl);
    end
endmodule

// File: rtl/dva_unit.sv
module dva_unit
    import dva_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_load,
    input  logic [DESC_W-1:0] req_desc,
    input  logic              req_modified,
    input  logic [MOD_W-1:0]  req_modifier,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data,
    output logic              bound_irq,
    output logic              illegal_flag
);
    state_t            state_q;
    plan_t             plan_c, plan_q;
    desc_t             eff_desc;
    logic [WORD_W-1:0] lo_q, hi_q, elem;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    dva_desc_reg u_desc (
        .clk      (clk),
        .rst      (rst),
        .take     (accept && req_load),
        .use_new  (req_load),
        .new_desc (req_desc),
        .eff_desc (eff_desc)
    );

    dva_addr_gen u_addr (
        .desc     (eff_desc),
        .modified (req_modified),
        .modifier (req_modifier),
        .plan     (plan_c)
    );

    dva_elem_align u_align (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .boff    (plan_q.boff),
        .szl     (plan_q.szl),
        .elem    (elem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            plan_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    plan_q  <= plan_c;
                    hi_q    <= '0;
                    state_q <= (plan_c.illegal || plan_c.bound_fail) ? ST_FAULT : ST_REQ0;
                end
                ST_FAULT: state_q <= ST_IDLE;
                ST_REQ0:  if (mem_req_ready) state_q <= ST_RSP0;
                ST_RSP0:  if (mem_rsp_valid) begin
                    lo_q    <= mem_rsp_data;
                    state_q <= plan_q.span2 ? ST_REQ1 : ST_DONE;
                end
                ST_REQ1:  if (mem_req_ready) state_q <= ST_RSP1;
                ST_RSP1:  if (mem_rsp_valid) begin
                    hi_q    <= mem_rsp_data;
                    state_q <= ST_DONE;
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == ST_REQ0) || (state_q == ST_REQ1);
    assign mem_addr      = (state_q == ST_REQ1) ? WA_W'(plan_q.waddr + 1'b1) : plan_q.waddr;
    assign mem_rsp_ready = (state_q == ST_RSP0) || (state_q == ST_RSP1);
    assign res_valid     = (state_q == ST_DONE);
    assign res_data      = res_valid ? elem : '0;
    assign illegal_flag  = (state_q == ST_FAULT) && plan_q.illegal;
    assign bound_irq     = (state_q == ST_FAULT) && !plan_q.illegal;
endmodule

// File: rtl/dva_chk.sv
module dva_chk
    import dva_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [WA_W-1:0] mem_addr,
    input logic            mem_rsp_ready,
    input logic            res_valid,
    input logic            bound_irq,
    input logic            illegal_flag
);
    // R1
    after_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_req_valid && !res_valid));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || mem_rsp_ready) |-> !req_ready);

    // R12
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, bound_irq, illegal_flag}));

    // R12
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid || bound_irq || illegal_flag) |=> !(res_valid || bound_irq || illegal_flag));

    // R4
    fault_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (bound_irq || illegal_flag) |-> (!mem_req_valid && !mem_rsp_ready));

    // R8
    accept_next_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_req_valid || bound_irq || illegal_flag));
endmodule

bind dva_unit dva_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_ready (mem_rsp_ready),
    .res_valid     (res_valid),
    .bound_irq     (bound_irq),
    .illegal_flag  (illegal_flag)
);

// File: tb/dva_unit_tb.sv
module dva_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_load = 1'b0, req_modified = 1'b0;
    logic [63:0] req_desc = '0;
    logic [31:0] req_modifier = '0;
    logic        req_ready;
    logic        mem_req_valid, mem_rsp_ready;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [28:0] mem_addr;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid, bound_irq, illegal_flag;
    logic [63:0] res_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int          kind;   // 0 data, 1 bound, 2 illegal
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [28:0] addr_q[$];
    logic [63:0] model_desc = '0;

    always #5 clk = ~clk;

    dva_unit u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_load(req_load),
        .req_desc(req_desc), .req_modified(req_modified), .req_modifier(req_modifier),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_data(res_data),
        .bound_irq(bound_irq), .illegal_flag(illegal_flag)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] mw(input logic [28:0] a);
        logic [31:0] x;
        x = {3'b000, a};
        return {(x * 32'h9E3779B1) ^ 32'h5A5AC3C3, (x ^ 32'h12345678) * 32'h85EBCA6B};
    endfunction

    task automatic issue(input logic ld, input logic [63:0] d, input logic md,
                         input logic [31:0] m, input string tag);
        exp_t        e;
        logic [63:0] use_d;
        logic [7:0]  ty;
        logic [2:0]  sl;
        logic [31:0] mm;
        logic [34:0] disp, bp;
        logic [28:0] wa;
        int          off, size;
        logic [127:0] j;
        logic        go;
        if (ld) model_desc = d;
        use_d = model_desc;
        ty = use_d[63:56];
        sl = ty[2:0];
        e.tag = tag;
        e.data = '0;
        if (sl == 3'd1 || sl == 3'd7) e.kind = 2;
        else if (md && !ty[3] && ($signed(m) < 0 || m >= {8'h00, use_d[55:32]})) e.kind = 1;
        else begin
            e.kind = 0;
            mm   = md ? m : 32'd0;
            size = 1 << sl;
            disp = ty[4] ? ({3'b000, mm} * 35'd8) : ({3'b000, mm} * 35'(size));
            bp   = {use_d[31:0], 3'b000} + disp;
            wa   = bp[34:6];
            off  = int'(bp[5:0]);
            addr_q.push_back(wa);
            if (off + size > 64) begin
                addr_q.push_back(wa + 29'd1);
                j = {mw(wa + 29'd1), mw(wa)};
            end else j = {64'd0, mw(wa)};
            j = j >> off;
            e.data = (size == 64) ? j[63:0] : (j[63:0] & ((64'd1 << size) - 64'd1));
        end
        exp_q.push_back(e);
        req_load = ld; req_desc = d; req_modified = md; req_modifier = m;
        req_valid = 1'b1;
        go = req_ready;
        @(negedge clk);
        while (!go) begin
            go = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Memory model, evaluated at falling edges
    initial begin : mem_model
        logic        req_hs, rsp_hs, pend;
        logic [28:0] pa;
        int          dly;
        req_hs = 0; rsp_hs = 0; pend = 0; pa = '0; dly = 0;
        forever begin
            @(negedge clk);
            if (rsp_hs) mem_rsp_valid = 1'b0;
            if (pend && !mem_rsp_valid) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mw(pa);
                    pend = 0;
                end else dly--;
            end
            mem_req_ready = (cyc % 3) != 0;
            req_hs = mem_req_valid && mem_req_ready && !rst;
            rsp_hs = mem_rsp_valid && mem_rsp_ready && !rst;
            if (req_hs) begin
                pa   = mem_addr;
                pend = 1;
                dly  = cyc % 2;
                if (addr_q.size() == 0)
                    check(1'b0, "R6 unexpected read", {35'd0, mem_addr}, 64'd0);
                else begin
                    logic [28:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_addr == ea, "R6/R10 address", {35'd0, mem_addr}, {35'd0, ea});
                end
                check(!req_ready, "R11 busy", {63'd0, req_ready}, 64'd0);
            end
        end
    end

    // Result monitor
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && (res_valid || bound_irq || illegal_flag)) begin
                check($countones({res_valid, bound_irq, illegal_flag}) == 1, "R12 single outcome",
                      {61'd0, res_valid, bound_irq, illegal_flag}, 64'd0);
                if (exp_q.size() == 0)
                    check(1'b0, "R12 unexpected result", res_data, 64'd0);
                else begin
                    exp_t e;
                    int   k;
                    e = exp_q.pop_front();
                    k = res_valid ? 0 : (bound_irq ? 1 : 2);
                    check(k == e.kind, {e.tag, " outcome kind"}, 64'(k), 64'(e.kind));
                    if (k == 0 && e.kind == 0)
                        check(res_data == e.data, {e.tag, " element data"}, res_data, e.data);
                end
            end
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [63:0] d8;
        d8 = {8'h03, 24'd10, 32'h0000_0100};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", {63'd0, req_ready}, 64'd1);
        check({mem_req_valid, mem_rsp_ready, res_valid, bound_irq, illegal_flag} == 5'd0,
              "R1 outputs idle", {59'd0, mem_req_valid, mem_rsp_ready, res_valid, bound_irq, illegal_flag}, 64'd0);

        issue(1, d8, 1, 32'd3, "R6 scaled byte");
        issue(0, 64'd0, 0, 32'd0, "R7 unmodified");
        issue(0, 64'd0, 1, 32'd9, "R4 last index");
        issue(0, 64'd0, 1, 32'd10, "R4 at bound");
        issue(0, 64'd0, 1, 32'hFFFF_FFFF, "R4 negative");
        issue(0, 64'd0, 1, 32'd5, "R3 reuse after fault");
        issue(1, {8'hE3, 24'd10, 32'h0000_0100}, 1, 32'd3, "R2 spare type bits");
        issue(1, {8'h0B, 24'd10, 32'h0000_0100}, 1, 32'd20, "R5 no check");
        issue(0, 64'd0, 1, 32'hFFFF_FFFE, "R5 negative unchecked");
        issue(1, {8'h15, 24'd8, 32'h0000_0200}, 1, 32'd4, "R6 unscaled word32");
        issue(1, {8'h05, 24'd8, 32'h0000_0200}, 1, 32'd3, "R6 scaled word32");
        issue(1, {8'h00, 24'd100, 32'h0000_0010}, 1, 32'd77, "R9 single bit");
        issue(1, {8'h02, 24'd50, 32'h0000_0011}, 1, 32'd13, "R9 nibble");
        issue(1, {8'h06, 24'd4, 32'h0000_0100}, 1, 32'd0, "R9 aligned 64");
        issue(1, {8'h04, 24'd9, 32'h0000_0003}, 1, 32'd2, "R10 straddle 16");
        issue(1, {8'h06, 24'd4, 32'h0000_0104}, 1, 32'd1, "R10 straddle 64");
        issue(1, {8'h16, 24'd4, 32'hFFFF_FFFC}, 0, 32'd0, "R10 wrap");
        issue(1, {8'h01, 24'd10, 32'h0000_0100}, 1, 32'd2, "R8 size 2");
        issue(1, {8'h07, 24'd10, 32'h0000_0100}, 1, 32'd50, "R8 priority");
        issue(0, 64'd0, 0, 32'd0, "R8 unmodified 128");
        issue(1, {8'h03, 24'd0, 32'h0000_0040}, 0, 32'd0, "R7 zero bound");
        issue(0, 64'd0, 1, 32'd0, "R4 zero bound");
        for (int i = 0; i < 24; i++) begin
            logic [7:0] ty;
            logic [2:0] s;
            s  = 3'(i % 7);
            if (s == 3'd1) s = 3'd3;
            ty = {3'b000, 1'b0, 1'(i % 3 == 0), s};
            issue(1, {ty, 24'(i * 7 + 5), 32'(i * 32'h0001_3579)}, 1, 32'(i * 3), "R9 sweep");
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && addr_q.size() == 0, "R12 queues drained",
              64'(exp_q.size() + addr_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule